// File: doc/BRIEF.md
# Boot Region Write-Lock Guard

This block sits beside the program controller of a sector-programmed flash array. It decides, cycle by cycle, whether a program or erase commit may go ahead. Two boot regions, the lowest and the highest 8 KB of a 128 KB byte address space, can each be locked on its own. A region is locked by a seven-step command sequence of its own. Once a region is locked, the lock cannot be undone by a soft reset. Commits that target a locked region are refused. Whole-array erase is refused while either lock is set.

Every permit also depends on general inhibit conditions. The write strobe must be qualified, with chip select low, write strobe low and output enable high, and it must have been held for a minimum number of cycles so that short glitches are rejected. Supply-good must have been stable for a power-up settling window. The same qualification gates the command events that drive the lock sequences. Both permit outputs are registered and appear one clock after the request. The lock bits model non-volatile storage: a separate power-on reset input clears them, and the soft reset does not.

Top module: `boot_lock_guard`

## Requirements
- R1: While `rst` or `por` is high, and on the first edge after either is raised, `write_ok` and `chip_erase_ok` are low.
- R2: When the write path is qualified and no lock covers `commit_addr`, `write_ok` is high on the edge after `commit_req` is high and low on the edge after it is low. `chip_erase_ok` follows `chip_erase_req` in the same way when no lock is set.
- R3: A set lock bit stays set through any number of soft resets (`rst`). Only `por` clears it.
- R4: A region locks on the seventh consecutive qualified `cmd_valid` event that matches its step table in order (steps 0..6). Steps 0..5 are shared by both regions: addresses 0x0A5A5, 0x15A5A, 0x0A5A5, 0x0A5A5, 0x15A5A, 0x0A5A5 with data 0xC3, 0x3C, 0x96, 0xC3, 0x3C, 0x69. Step 6 is address 0x0A5A5 with data 0x0F for the low region and data 0xF0 for the high region. Any qualified event that does not match the expected step sends that region's detector back to step 0.
- R5: While the low lock is set, a commit to an address below 0x02000 gets no `write_ok`. While the high lock is set, a commit to an address at or above 0x1E000 gets no `write_ok`.
- R6: While either lock is set, `chip_erase_ok` stays low.
- R7: While `oe_n` is low, `ce_n` is high or `we_n` is high, no permit is granted on the next edge, and `cmd_valid` events have no effect on the lock sequences.
- R8: After `pwr_good` rises, permits first appear on the edge following `PWR_DLY_CYC` edges with `pwr_good` high. When `pwr_good` falls, permits drop on the next edge.
- R9: A request is honoured only on an edge at which the strobe has already been qualified for at least `GLITCH_CYC` consecutive earlier edges. Shorter strobe pulses grant nothing.
- R10: Locking one region leaves commits to the other region and to the middle of the array permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous soft reset, active high; keeps the lock bits |
| por | input | 1 | Synchronous power-on reset, active high; also clears the lock bits |
| pwr_good | input | 1 | Supply valid |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| cmd_valid | input | 1 | Decoded command write event |
| cmd_addr | input | ADDR_W | Command event address |
| cmd_data | input | DATA_W | Command event data |
| commit_req | input | 1 | Program or sector-erase commit request |
| commit_addr | input | ADDR_W | Target address of the commit |
| chip_erase_req | input | 1 | Whole-array erase request |
| write_ok | output | 1 | Registered commit permit |
| chip_erase_ok | output | 1 | Registered whole-array erase permit |

## Verification
The bench goes after the exact region edges: 0x01FFF against 0x02000, and 0x1DFFF against 0x1E000. A decoder off by one bit there would refuse legitimate writes next to a boot region, or let a write into one. It breaks a lock sequence in the middle and then completes the remaining steps. A detector that resumed instead of restarting would then lock the region. It also sends a full sequence while the strobe is inhibited, and a guard that counted those events would lock the region anyway. It measures the exact edge at which permits first appear after power-up and after a fresh strobe, which exposes counters that are one cycle early or late. Last, it pulses the soft reset after locking, which would open a region if the locks were wrongly tied to that reset.

// File: rtl/blg_pkg.sv
package blg_pkg;
  localparam int SEQ_LEN     = 7;
  localparam int NUM_REGIONS = 2;

  typedef enum logic [0:0] {
    REG_LOW  = 1'b0,
    REG_HIGH = 1'b1
  } region_e;
endpackage

// File: rtl/blg_write_qual.sv
module blg_write_qual #(
  parameter int PWR_DLY_CYC = 2_500_000,
  parameter int GLITCH_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_allowed
);
  localparam int PW = $clog2(PWR_DLY_CYC + 1);
  localparam int GW = $clog2(GLITCH_CYC + 1);

  logic [PW-1:0] pwr_cnt;
  logic          pwr_ready;
  logic [GW-1:0] stb_cnt;
  logic          stb_raw;

  // supply settling window
  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_cnt   <= '0;
      pwr_ready <= 1'b0;
    end else if (!pwr_good) begin
      pwr_cnt   <= '0;
      pwr_ready <= 1'b0;
    end else if (!pwr_ready) begin
      if (pwr_cnt == PW'(PWR_DLY_CYC - 1)) pwr_ready <= 1'b1;
      else                                 pwr_cnt   <= pwr_cnt + 1'b1;
    end
  end

  // strobe qualification with a minimum hold time
  assign stb_raw = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (rst || !stb_raw)                 stb_cnt <= '0;
    else if (stb_cnt != GW'(GLITCH_CYC)) stb_cnt <= stb_cnt + 1'b1;
  end

  assign wr_allowed = pwr_ready && pwr_good && stb_raw &&
                      (stb_cnt == GW'(GLITCH_CYC));

  AST_PWR_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (pwr_good && pwr_ready) |=> pwr_ready); // R8
  AST_STB_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !stb_raw |=> (stb_cnt == '0)); // R9
endmodule

// File: rtl/blg_seq_detect.sv
module blg_seq_detect
  import blg_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter logic [SEQ_LEN-1:0][ADDR_W-1:0] SEQ_ADDR = '0,
  parameter logic [SEQ_LEN-1:0][DATA_W-1:0] SEQ_DATA = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              arm_pulse
);
  localparam int SW = $clog2(SEQ_LEN);

  logic [SW-1:0] step;
  logic          step_match;
  logic          last_step;

  assign step_match = (cmd_addr == SEQ_ADDR[step]) && (cmd_data == SEQ_DATA[step]);
  assign last_step  = (step == SW'(SEQ_LEN - 1));
  assign arm_pulse  = accept && step_match && last_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (accept) begin
      if (step_match && !last_step) step <= step + 1'b1;
      else                          step <= '0;
    end
  end

  AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (rst)
    (accept && !step_match) |=> (step == '0)); // R4
  AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (rst)
    accept |=> (step < SW'(SEQ_LEN))); // R4
  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(step)); // R7
endmodule

// File: rtl/blg_lock_store.sv
module blg_lock_store #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           por,
  input  logic [NUM-1:0] set_req,
  output logic [NUM-1:0] lock_q
);
  always_ff @(posedge clk) begin
    if (por) lock_q <= '0;
    else     lock_q <= lock_q | set_req;
  end

  for (genvar i = 0; i < NUM; i++) begin : g_sticky
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (por)
      lock_q[i] |=> lock_q[i]); // R3
  end
endmodule

// File: rtl/boot_lock_guard.sv
module boot_lock_guard
  import blg_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int REGION_W    = 13,
  parameter int PWR_DLY_CYC = 2_500_000,
  parameter int GLITCH_CYC  = 4,
  parameter logic [SEQ_LEN-1:0][ADDR_W-1:0] LO_SEQ_ADDR =
    {17'h0A5A5, 17'h0A5A5, 17'h15A5A, 17'h0A5A5, 17'h0A5A5, 17'h15A5A, 17'h0A5A5},
  parameter logic [SEQ_LEN-1:0][DATA_W-1:0] LO_SEQ_DATA =
    {8'h0F, 8'h69, 8'h3C, 8'hC3, 8'h96, 8'h3C, 8'hC3},
  parameter logic [SEQ_LEN-1:0][ADDR_W-1:0] HI_SEQ_ADDR =
    {17'h0A5A5, 17'h0A5A5, 17'h15A5A, 17'h0A5A5, 17'h0A5A5, 17'h15A5A, 17'h0A5A5},
  parameter logic [SEQ_LEN-1:0][DATA_W-1:0] HI_SEQ_DATA =
    {8'hF0, 8'h69, 8'h3C, 8'hC3, 8'h96, 8'h3C, 8'hC3}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              pwr_good,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              commit_req,
  input  logic [ADDR_W-1:0] commit_addr,
  input  logic              chip_erase_req,
  output logic              write_ok,
  output logic              chip_erase_ok
);
  localparam int TAG_W = ADDR_W - REGION_W;
  localparam int LO    = int'(REG_LOW);
  localparam int HI    = int'(REG_HIGH);

  logic                   sreset;
  logic                   wr_allowed;
  logic                   accept;
  logic [NUM_REGIONS-1:0] arm_set;
  logic [NUM_REGIONS-1:0] lock_q;
  logic [NUM_REGIONS-1:0] region_hit;
  logic [TAG_W-1:0]       commit_tag;
  logic                   target_locked;

  assign sreset = rst || por;

  blg_write_qual #(
    .PWR_DLY_CYC (PWR_DLY_CYC),
    .GLITCH_CYC  (GLITCH_CYC)
  ) u_qual (
    .clk        (clk),
    .rst        (sreset),
    .pwr_good   (pwr_good),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .we_n       (we_n),
    .wr_allowed (wr_allowed)
  );

  assign accept = cmd_valid && wr_allowed;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    blg_seq_detect #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SEQ_ADDR ((r == LO) ? LO_SEQ_ADDR : HI_SEQ_ADDR),
      .SEQ_DATA ((r == LO) ? LO_SEQ_DATA : HI_SEQ_DATA)
    ) u_seq (
      .clk       (clk),
      .rst       (sreset),
      .accept    (accept),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .arm_pulse (arm_set[r])
    );
  end

  blg_lock_store #(.NUM(NUM_REGIONS)) u_locks (
    .clk     (clk),
    .por     (por),
    .set_req (arm_set),
    .lock_q  (lock_q)
  );

  // boot regions: all-zero or all-one upper address bits
  assign commit_tag     = commit_addr[ADDR_W-1:REGION_W];
  assign region_hit[LO] = (commit_tag == '0);
  assign region_hit[HI] = (commit_tag == '1);
  assign target_locked  = |(region_hit & lock_q);

  always_ff @(posedge clk) begin
    if (sreset) begin
      write_ok      <= 1'b0;
      chip_erase_ok <= 1'b0;
    end else begin
      write_ok      <= commit_req && wr_allowed && !target_locked;
      chip_erase_ok <= chip_erase_req && wr_allowed && (lock_q == '0);
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    sreset |=> (!write_ok && !chip_erase_ok)); // R1
  AST_NO_REQ_NO_PERMIT: assert property (@(posedge clk) disable iff (sreset)
    !commit_req |=> !write_ok); // R2
  AST_LOW_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (sreset)
    (commit_req && region_hit[LO] && lock_q[LO]) |=> !write_ok); // R5
  AST_HIGH_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (sreset)
    (commit_req && region_hit[HI] && lock_q[HI]) |=> !write_ok); // R5
  AST_ERASE_BLOCKED: assert property (@(posedge clk) disable iff (sreset)
    (lock_q != '0) |=> !chip_erase_ok); // R6
  AST_STROBE_INHIBIT: assert property (@(posedge clk) disable iff (sreset)
    (!oe_n || ce_n || we_n) |=> (!write_ok && !chip_erase_ok)); // R7
  AST_NO_POWER: assert property (@(posedge clk) disable iff (sreset)
    !pwr_good |=> (!write_ok && !chip_erase_ok)); // R8
endmodule

// File: tb/test_boot_lock_guard.sv
module test_boot_lock_guard;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int D  = 20;
  localparam int G  = 3;

  localparam logic [AW-1:0] SQA [7] =
    '{17'h0A5A5, 17'h15A5A, 17'h0A5A5, 17'h0A5A5, 17'h15A5A, 17'h0A5A5, 17'h0A5A5};
  localparam logic [DW-1:0] SQD [6] = '{8'hC3, 8'h3C, 8'h96, 8'hC3, 8'h3C, 8'h69};
  localparam logic [DW-1:0] LAST_LO = 8'h0F;
  localparam logic [DW-1:0] LAST_HI = 8'hF0;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          wreq;
    logic          ereq;
    logic          exp_w;
    logic          exp_e;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{17'h00000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{17'h1FFFF, 1'b1, 1'b1, 1'b1, 1'b1},
    '{17'h10000, 1'b0, 1'b1, 1'b0, 1'b1},
    '{17'h0FFFF, 1'b0, 1'b0, 1'b0, 1'b0},
    '{17'h02000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{17'h1E000, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst, por, pwr_good, ce_n, oe_n, we_n;
  logic cmd_valid, commit_req, chip_erase_req;
  logic [AW-1:0] cmd_addr, commit_addr;
  logic [DW-1:0] cmd_data;
  logic write_ok, chip_erase_ok;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  boot_lock_guard #(
    .ADDR_W (AW), .DATA_W (DW), .REGION_W (13),
    .PWR_DLY_CYC (D), .GLITCH_CYC (G)
  ) i_boot_lock_guard (
    .clk (clk), .rst (rst), .por (por), .pwr_good (pwr_good),
    .ce_n (ce_n), .oe_n (oe_n), .we_n (we_n),
    .cmd_valid (cmd_valid), .cmd_addr (cmd_addr), .cmd_data (cmd_data),
    .commit_req (commit_req), .commit_addr (commit_addr),
    .chip_erase_req (chip_erase_req),
    .write_ok (write_ok), .chip_erase_ok (chip_erase_ok)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic recover();
    pwr_good = 1'b1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    commit_req = 1'b0; chip_erase_req = 1'b0; cmd_valid = 1'b0;
    repeat (D + G + 2) tick();
  endtask

  task automatic send_cmd(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    tick();
    cmd_valid = 1'b0;
  endtask

  // break_at >= 0 replaces that step with a wrong data value
  task automatic send_lock(input bit hi, input int break_at);
    for (int s = 0; s < 7; s++) begin
      logic [DW-1:0] d;
      d = (s == 6) ? (hi ? LAST_HI : LAST_LO) : SQD[s];
      if (s == break_at) d = 8'h00;
      send_cmd(SQA[s], d);
    end
  endtask

  task automatic try_write(input string tag, input logic [AW-1:0] a, input logic exp);
    commit_req = 1'b1; commit_addr = a;
    tick();
    check(tag, write_ok, exp);
    commit_req = 1'b0;
    tick();
  endtask

  task automatic try_erase(input string tag, input logic exp);
    chip_erase_req = 1'b1;
    tick();
    check(tag, chip_erase_ok, exp);
    chip_erase_req = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int first;
    rst = 1'b1; por = 1'b1; pwr_good = 1'b0;
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    cmd_valid = 1'b0; cmd_addr = '0; cmd_data = '0;
    commit_req = 1'b1; commit_addr = 17'h04000; chip_erase_req = 1'b1;
    repeat (3) tick();
    // R1: both resets held, requests high
    check("R1 write_ok in reset", write_ok, 1'b0);
    check("R1 chip_erase_ok in reset", chip_erase_ok, 1'b0);
    rst = 1'b0; por = 1'b0; chip_erase_req = 1'b0;
    tick();

    // R8: first permit edge after pwr_good rises
    pwr_good = 1'b1;
    first = -1;
    for (int k = 1; k <= D + 5; k++) begin
      tick();
      if (write_ok && first < 0) first = k;
    end
    check_int("R8 first permit edge after power up", first, D + 1);
    pwr_good = 1'b0;
    tick();
    check("R8 permit drops with pwr_good", write_ok, 1'b0);
    recover();

    // R2, R6: vector table with no lock set
    for (int i = 0; i < 6; i++) begin
      commit_req = TBL[i].wreq; commit_addr = TBL[i].addr;
      chip_erase_req = TBL[i].ereq;
      tick();
      check($sformatf("R2 table write_ok vec %0d", i), write_ok, TBL[i].exp_w);
      check($sformatf("R6 table chip_erase_ok vec %0d", i), chip_erase_ok, TBL[i].exp_e);
    end
    commit_req = 1'b0; chip_erase_req = 1'b0;
    tick();

    // R7: each inhibit condition
    commit_req = 1'b1; commit_addr = 17'h04000; chip_erase_req = 1'b1;
    oe_n = 1'b0; tick();
    check("R7 oe_n low inhibits write", write_ok, 1'b0);
    check("R7 oe_n low inhibits erase", chip_erase_ok, 1'b0);
    oe_n = 1'b1; ce_n = 1'b1; tick();
    check("R7 ce_n high inhibits write", write_ok, 1'b0);
    ce_n = 1'b0; we_n = 1'b1; tick();
    check("R7 we_n high inhibits write", write_ok, 1'b0);

    // R9: glitch filter, permit on edge G+1 of a fresh strobe
    we_n = 1'b0; chip_erase_req = 1'b0;
    first = -1;
    for (int k = 1; k <= G + 3; k++) begin
      tick();
      if (write_ok && first < 0) first = k;
    end
    check_int("R9 first permit edge after strobe start", first, G + 1);
    commit_req = 1'b0;
    tick();

    // R7: lock sequence under inhibited strobe is ignored
    oe_n = 1'b0;
    send_lock(1'b0, -1);
    oe_n = 1'b1;
    repeat (G + 1) tick();
    try_write("R7 inhibited sequence leaves low region open", 17'h00100, 1'b1);

    // R4: broken sequence does not lock
    send_lock(1'b0, 3);
    try_write("R4 broken sequence leaves low region open", 17'h00100, 1'b1);

    // R4, R5, R10, R6: lock the low region
    send_lock(1'b0, -1);
    try_write("R5 low locked, addr 0x00100", 17'h00100, 1'b0);
    try_write("R5 low locked, addr 0x01FFF", 17'h01FFF, 1'b0);
    try_write("R10 low locked, addr 0x02000 open", 17'h02000, 1'b1);
    try_write("R10 low locked, high region open", 17'h1F000, 1'b1);
    try_erase("R6 erase refused with low lock", 1'b0);

    // R3: soft reset keeps the lock
    rst = 1'b1; tick(); tick();
    check("R1 soft reset clears write_ok", write_ok, 1'b0);
    rst = 1'b0;
    recover();
    try_write("R3 low lock survives soft reset", 17'h00100, 1'b0);

    // R4, R5: lock the high region
    send_lock(1'b1, -1);
    try_write("R5 high locked, addr 0x1E000", 17'h1E000, 1'b0);
    try_write("R5 high locked, addr 0x1FFFF", 17'h1FFFF, 1'b0);
    try_write("R10 high locked, addr 0x1DFFF open", 17'h1DFFF, 1'b1);

    // R3: power-on reset clears locks
    por = 1'b1; tick(); tick();
    por = 1'b0;
    recover();
    try_write("R3 por clears low lock", 17'h00100, 1'b1);
    try_write("R3 por clears high lock", 17'h1E000, 1'b1);
    try_erase("R6 erase allowed after por", 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule